// File: doc/BRIEF.md
# Three-channel interval timer

This block holds three independent 16-bit down-counters. They advance on a free-running tick enable of about 1.19 MHz, which gives one tick every 838 ns or so. Software drives the timer through byte-wide accesses on a small address space. One shared control address selects a channel's counting mode and byte access order, or freezes a snapshot of its count. Each channel also has its own data address, where the reload value is written and the count is read back.

Each channel supports three behaviours. A one-shot terminal-count mode raises the output and holds it high. A rate generator drops its output for one tick once per period. A square-wave generator halves the period between output toggles. Channel 0's output is the interrupt request line. Channel 2's output can be read, together with a 4-bit speaker control nibble, at an auxiliary address.

Address map: 0, 1 and 2 are the channel data ports, 3 is the control port, and 4 is the auxiliary port. Addresses 5 to 7 read as zero and ignore writes.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every count, reload and snapshot is 0, no channel counts, every channel output is low, the speaker nibble is 0, and every channel uses low-then-high byte order in one-shot mode.
- R2: A byte written to address 3 is a control word. Bits 7:6 select the channel, and the value 3 is ignored. Bits 5:4 select the access order: 1 low only, 2 high only, 3 low then high. Bits 3:1 select the mode: 0 one-shot, 2 or 6 rate, 3 or 7 square, any other value leaves the channel idle. When bits 5:0 are not all zero, the word clears the count, the reload and the running state, and it sets the output low for one-shot mode and high for every other mode.
- R3: A control word whose bits 5:0 are zero copies the live count into a snapshot. The next data read returns the snapshot's low byte and the read after that returns its high byte. Reads then return the live count in the channel's access order.
- R4: With access order 3, successive data reads alternate low byte then high byte, and successive data writes do the same. With order 1 every access uses the low byte, and with order 2 every access uses the high byte.
- R5: In one-shot mode every data write drives the output low. The count loads and counting starts only once the reload is complete, which with order 3 means after the high byte. The output goes high on the tick that takes the count from 1 to 0 and stays high until the next data or control write. A reload of 0 takes 65536 ticks.
- R6: In rate and square modes a completed reload write starts the channel only when it is not already running. A running channel keeps its count and picks up the new reload at its next expiry.
- R7: In rate mode the count falls by 1 per tick and reloads on the tick after it reaches 1. The output is low exactly while the count is 1, so the period is the reload value in ticks. A reload of 0 gives 65536 ticks.
- R8: In square mode the count falls by 2 per tick. On a tick that finds the count at 1 or 2, the output toggles and the count reloads. A reload of 0 or 1 counts as 65536, so each output half-period is the reload divided by 2, rounded up, in ticks.
- R9: `irq0` always equals channel 0's output.
- R10: A read of address 4 returns {2'b00, channel 2 output, 1'b0, speaker nibble}. A write to address 4 stores only bits 3:0 of the data.
- R11: Counts change only on cycles with `tick` high, or on a control write or data write to that channel. A data or control write to a channel takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one cycle per timer tick |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; advances the read byte order |
| addr | input | 3 | Port address (0-2 data, 3 control, 4 auxiliary) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port, combinational |
| ch_out | output | 3 | Channel outputs |
| irq0 | output | 1 | Interrupt request from channel 0 |

## Verification
Counts, outputs and the byte-order state change on the clock edge that samples a tick or a write. `rdata` is combinational, so it reflects the state before that edge. The bench drives each strobe for a single cycle, starting at a falling edge. It reads `rdata` 1 ns into the strobe cycle. It samples `ch_out`, `irq0` and snapshot values only after the edge that consumed the strobe, one cycle after each tick pulse. Expected counts and output levels come from closed-form functions of the reload value and the number of ticks given.

// File: rtl/tri_interval_timer.sv
`timescale 1ns/1ps
module tri_interval_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [2:0] ch_out,
  output logic       irq0
);
  localparam int NCH = 3;

  typedef enum logic [1:0] {K_TC, K_RATE, K_SQ, K_IDLE} kind_t;
  typedef enum logic [1:0] {RS_LO, RS_HI, RS_LLO, RS_LHI} rsel_t;

  kind_t       kind [NCH];
  rsel_t       rs   [NCH];
  logic [1:0]  acc  [NCH];
  logic [15:0] cnt  [NCH];
  logic [15:0] rld  [NCH];
  logic [15:0] lat  [NCH];
  logic        run  [NCH];
  logic        whi  [NCH];
  logic [2:0]  outq;
  logic [3:0]  spk;

  logic [15:0] step_cnt [NCH];
  logic [15:0] nrld     [NCH];
  logic [2:0]  step_out, dwr, drd, hib, done;

  wire       ctl_wr    = wr_en && addr == 3'd3 && wdata[7:6] != 2'b11;
  wire [1:0] ctl_ch    = wdata[7:6];
  wire       ctl_latch = wdata[5:0] == 6'd0;

  function automatic kind_t decode(input logic [2:0] m);
    case (m)
      3'd0:       return K_TC;
      3'd2, 3'd6: return K_RATE;
      3'd3, 3'd7: return K_SQ;
      default:    return K_IDLE;
    endcase
  endfunction

  function automatic rsel_t live_sel(input logic [1:0] a);
    return (a == 2'd2) ? RS_HI : RS_LO;
  endfunction

  function automatic logic [15:0] sq_len(input logic [15:0] r);
    return (r <= 16'd1) ? 16'd0 : r;
  endfunction

  always_comb begin
    step_out = outq;
    for (int i = 0; i < NCH; i++) begin
      dwr[i]  = wr_en && addr == 3'(i);
      drd[i]  = rd_en && addr == 3'(i);
      hib[i]  = acc[i] == 2'd2 || (acc[i] == 2'd3 && whi[i]);
      done[i] = acc[i] != 2'd3 || whi[i];
      nrld[i] = hib[i] ? {wdata, rld[i][7:0]} : {rld[i][15:8], wdata};
      step_cnt[i] = cnt[i];
      case (kind[i])
        K_TC: begin
          step_cnt[i] = cnt[i] - 16'd1;
          if (cnt[i] == 16'd1) step_out[i] = 1'b1;
        end
        K_RATE: begin
          step_cnt[i] = (cnt[i] == 16'd1) ? rld[i] : cnt[i] - 16'd1;
          step_out[i] = step_cnt[i] != 16'd1;
        end
        K_SQ: begin
          if (cnt[i] == 16'd1 || cnt[i] == 16'd2) begin
            step_cnt[i] = sq_len(rld[i]);
            step_out[i] = ~outq[i];
          end else begin
            step_cnt[i] = cnt[i] - 16'd2;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outq <= '0;
      spk  <= '0;
      for (int i = 0; i < NCH; i++) begin
        kind[i] <= K_TC;
        rs[i]   <= RS_LO;
        acc[i]  <= 2'd3;
        cnt[i]  <= '0;
        rld[i]  <= '0;
        lat[i]  <= '0;
        run[i]  <= 1'b0;
        whi[i]  <= 1'b0;
      end
    end else begin
      if (wr_en && addr == 3'd4) spk <= wdata[3:0];
      for (int i = 0; i < NCH; i++) begin
        if (ctl_wr && ctl_ch == 2'(i)) begin
          if (ctl_latch) begin
            lat[i] <= cnt[i];
            rs[i]  <= RS_LLO;
          end else begin
            kind[i] <= decode(wdata[3:1]);
            acc[i]  <= wdata[5:4];
            run[i]  <= 1'b0;
            cnt[i]  <= '0;
            rld[i]  <= '0;
            whi[i]  <= 1'b0;
            rs[i]   <= live_sel(wdata[5:4]);
            outq[i] <= decode(wdata[3:1]) != K_TC;
          end
        end else if (dwr[i]) begin
          rld[i] <= nrld[i];
          if (acc[i] == 2'd3) whi[i] <= ~whi[i];
          case (kind[i])
            K_TC: begin
              outq[i] <= 1'b0;
              run[i]  <= done[i];
              if (done[i]) cnt[i] <= nrld[i];
            end
            K_RATE: if (!run[i] && done[i]) begin
              cnt[i] <= nrld[i];
              run[i] <= 1'b1;
            end
            K_SQ: if (!run[i] && done[i]) begin
              cnt[i] <= sq_len(nrld[i]);
              run[i] <= 1'b1;
            end
            default: ;
          endcase
        end else if (tick && run[i]) begin
          cnt[i]  <= step_cnt[i];
          outq[i] <= step_out[i];
        end

        if (drd[i]) begin
          case (rs[i])
            RS_LO:  if (acc[i] == 2'd3) rs[i] <= RS_HI;
            RS_HI:  if (acc[i] == 2'd3) rs[i] <= RS_LO;
            RS_LLO: rs[i] <= RS_LHI;
            default: rs[i] <= live_sel(acc[i]);
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == 3'd4) rdata = {2'b00, outq[2], 1'b0, spk};
    for (int i = 0; i < NCH; i++) begin
      if (addr == 3'(i)) begin
        case (rs[i])
          RS_LO:  rdata = cnt[i][7:0];
          RS_HI:  rdata = cnt[i][15:8];
          RS_LLO: rdata = lat[i][7:0];
          default: rdata = lat[i][15:8];
        endcase
      end
    end
  end

  assign ch_out = outq;
  assign irq0   = outq[0];

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_tc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind[g] == K_TC && outq[g] && !(wr_en && (addr == 3'(g) || addr == 3'd3)))
      |=> outq[g]);
    p_rate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind[g] == K_RATE && run[g] && !outq[g]) |-> cnt[g] == 16'd1);
    p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(wr_en && (addr == 3'(g) || addr == 3'd3))) |=> $stable(cnt[g]));
    p_latch_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rs[g] == RS_LHI |-> $past(rs[g] == RS_LLO || rs[g] == RS_LHI));
    p_sq_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind[g] == K_SQ && $past(kind[g] == K_SQ) && outq[g] != $past(outq[g])
       && $past(!(wr_en && addr == 3'd3))) |-> $past(tick && run[g]));
  end
endmodule

// File: tb/tri_interval_timer_test.sv
`timescale 1ns/1ps
module tri_interval_timer_test;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] ch_out;
  logic       irq0;
  int nchk = 0, nerr = 0;

  tri_interval_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .ch_out(ch_out), .irq0(irq0));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic latch_rd(input int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(3'd3, {2'(ch), 6'd0});
    rd(3'(ch), lo);
    rd(3'(ch), hi);
    v = {hi, lo};
  endtask

  function automatic logic rate_out(input int r, input int k);
    int p = (r == 0) ? 65536 : r;
    return (p - (k % p)) != 1;
  endfunction

  function automatic logic [15:0] rate_cnt(input int r, input int k);
    int p = (r == 0) ? 65536 : r;
    return 16'(p - (k % p));
  endfunction

  function automatic logic sq_out(input int r, input int k);
    int p = (r <= 1) ? 65536 : r;
    int h = (p + 1) / 2;
    return ((k / h) % 2) == 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] b, b2;
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd4, b);       check("R1 aux after reset", b, 8'h00);
    check("R1 outputs after reset", {ch_out, irq0}, 4'h0);
    latch_rd(0, v);    check("R1 count after reset", v, 16'h0000);

    wr(3'd3, 8'h30);   check("R2 one-shot config output low", ch_out[0], 1'b0);
    wr(3'd0, 8'd5);    ticks(3);
    latch_rd(0, v);    check("R5 no count before high byte", v, 16'h0000);
    wr(3'd0, 8'd0);    ticks(4);
    check("R5 output low before terminal", ch_out[0], 1'b0);
    latch_rd(0, v);    check("R5 count after 4 ticks", v, 16'd1);
    ticks(1);
    check("R5 output high at terminal", ch_out[0], 1'b1);
    check("R9 irq0 follows channel 0", irq0, 1'b1);
    ticks(3);          check("R5 output stays high", ch_out[0], 1'b1);
    wr(3'd0, 8'd9);    check("R5 rewrite drives low", ch_out[0], 1'b0);
    check("R9 irq0 low", irq0, 1'b0);

    wr(3'd3, 8'h20);   wr(3'd0, 8'h01);
    rd(3'd0, b); rd(3'd0, b2);
    check("R4 high-only first read", b, 8'h01);
    check("R4 high-only second read", b2, 8'h01);
    ticks(1); rd(3'd0, b);
    check("R4 high-only after tick", b, 8'h00);
    wr(3'd3, 8'h50);   wr(3'd1, 8'd7);
    rd(3'd1, b); rd(3'd1, b2);
    check("R4 low-only reads", {b, b2}, 16'h0707);
    ticks(2); rd(3'd1, b);
    check("R4 low-only after ticks", b, 8'd5);

    wr(3'd3, 8'h74);   check("R2 rate config output high", ch_out[1], 1'b1);
    wr(3'd1, 8'd10);   wr(3'd1, 8'd0);
    ticks(3);          wr(3'd3, 8'h40);
    ticks(2);
    rd(3'd1, b); rd(3'd1, b2);
    check("R3 snapshot bytes", {b2, b}, 16'd7);
    rd(3'd1, b); rd(3'd1, b2);
    check("R3 live after snapshot", {b2, b}, 16'd5);

    wr(3'd3, 8'h74);   wr(3'd1, 8'd4); wr(3'd1, 8'd0);
    for (int k = 1; k <= 10; k++) begin
      ticks(1);
      check("R7 rate output", ch_out[1], rate_out(4, k));
    end
    wr(3'd1, 8'd8);    wr(3'd1, 8'd0);
    latch_rd(1, v);    check("R6 running count kept", v, rate_cnt(4, 10));
    ticks(2);
    latch_rd(1, v);    check("R6 new reload at expiry", v, 16'd8);

    wr(3'd3, 8'hB6);
    rd(3'd4, b);       check("R2 square config output high", b[5], 1'b1);
    wr(3'd2, 8'd6);    wr(3'd2, 8'd0);
    for (int k = 1; k <= 12; k++) begin
      ticks(1); rd(3'd4, b);
      check("R8 square even reload", b[5], sq_out(6, k));
    end
    wr(3'd3, 8'hB6);   wr(3'd2, 8'd5); wr(3'd2, 8'd0);
    for (int k = 1; k <= 12; k++) begin
      ticks(1);
      if (k == 4) begin
        wr(3'd3, 8'hFE); wr(3'd3, 8'hC0);
      end
      check("R8 square odd reload (R2 channel 3 ignored)", ch_out[2], sq_out(5, k));
    end
    wr(3'd3, 8'hB6);   wr(3'd2, 8'd1); wr(3'd2, 8'd0);
    ticks(1);
    latch_rd(2, v);    check("R8 reload 1 as 65536", v, 16'hFFFE);
    check("R8 no toggle yet", ch_out[2], 1'b1);

    wr(3'd3, 8'h34);   wr(3'd0, 8'd0); wr(3'd0, 8'd0);
    ticks(1);
    latch_rd(0, v);    check("R7 reload 0 as 65536", v, 16'hFFFF);
    check("R7 output high", ch_out[0], 1'b1);
    repeat (10) @(negedge clk);
    latch_rd(0, v);    check("R11 frozen without tick", v, 16'hFFFF);

    wr(3'd4, 8'hAF);   rd(3'd4, b);
    check("R10 aux nibble and channel 2", b, 8'h2F);

    wr(3'd3, 8'h32);   wr(3'd0, 8'd5); wr(3'd0, 8'd0);
    ticks(3);
    latch_rd(0, v);    check("R2 unsupported mode idle", v, 16'h0000);
    check("R2 unsupported mode output high", ch_out[0], 1'b1);

    for (int it = 0; it < 16; it++) begin
      int r, n;
      r = 2 + int'($urandom % 40);
      n = int'($urandom % r);
      wr(3'd3, 8'h30); wr(3'd0, 8'(r)); wr(3'd0, 8'd0);
      ticks(n);
      latch_rd(0, v);  check("R5 random one-shot count", v, 16'(r - n));
      check("R5 random one-shot output", ch_out[0], 1'b0);
      r = 2 + int'($urandom % 8);
      n = int'($urandom % 20);
      wr(3'd3, 8'h74); wr(3'd1, 8'(r)); wr(3'd1, 8'd0);
      ticks(n);
      check("R7 random rate output", ch_out[1], rate_out(r, n));
      latch_rd(1, v);  check("R7 random rate count", v, rate_cnt(r, n));
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule